// File: doc/BRIEF.md
# Pull-Up Strength Calibration Sequencer

This block finds the weakest programmable pull-up setting that still lets an open switch input charge to a logic high. A one-clock start request begins a search. The block then drives a 5-bit strength code to the pull-up control and steps it from the weakest code toward stronger ones. Each code is held for a fixed number of sample ticks, and the ticks come from a slow real-time sampling clock. The comparator output of one of two input channels is watched. The same resulting code is applied to both channels.

While a search runs, the block raises a freeze output. The debounce integrators and the pulse counters use it to ignore their comparator inputs and stop counting. A search ends early at the first code whose input reads high on the final tick of its test window. That code is stored in the result register and a one-clock done pulse is given. If the input never reads high over the whole sequence of tests, the fail flag is set and the previous result is kept. Because the test length is counted in sample ticks, a slower sample rate makes calibration take longer in proportion.

Top module: `pullup_cal_seq`

## Requirements
- R1: After reset, freeze, done and fail are low, and both the result register and pull_code are 0.
- R2: A start pulse while idle raises freeze in the next clock. Freeze stays high until the sequence ends and is low whenever the block is idle.
- R3: Codes are tried from 0 upward in steps of one. Each code is held for exactly 3 sample ticks, and the selected input is judged only on the third tick of each code.
- R4: The channel is chosen by chan_sel, sampled when the start pulse is accepted: 0 watches comp_in[0] and 1 watches comp_in[1].
- R5: The first code whose selected input is high on its judging tick becomes the result, and the sequence stops there. A pass at code k takes 3*(k+1) sample ticks.
- R6: If all 28 codes (0 to 27) fail, the sequence ends after 84 sample ticks with fail high, and the result keeps its previous value.
- R7: done is high for exactly one clock, in the clock after the deciding tick. fail stays high until the next accepted start, which clears it.
- R8: A start pulse while a sequence is running is ignored: the code in test and the tick count go on unchanged.
- R9: While idle, pull_code equals the result register, so the calibrated code drives both channels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_tick | input | 1 | One-clock pulse per sample period |
| start | input | 1 | Calibration request pulse |
| chan_sel | input | 1 | Channel used for calibration (0 or 1) |
| comp_in | input | 2 | Comparator outputs of the two channels |
| pull_code | output | 5 | Strength code to the pull-up control |
| freeze | output | 1 | Holds the integrators and counters during calibration |
| done | output | 1 | One-clock end-of-sequence pulse |
| fail | output | 1 | Last sequence found no passing code |
| result | output | 5 | Last successful calibration code |

## Verification
A wrong code counter or tick counter shows up as a wrong result or a wrong number of sample ticks between start and done. The bench can see this at the done pulse of the same run. A bad latched channel gives the other channel's threshold as the result. An error in the fail path shows as a result that has been overwritten, or as a fail flag that stays set after the next start. Both can be seen in the first clock after done, or one clock after the following start.

// File: rtl/pullup_cal_seq.sv
module pullup_cal_seq #(
  parameter int CODE_W         = 5,
  parameter int NUM_TESTS      = 28,
  parameter int TICKS_PER_TEST = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_tick,
  input  logic              start,
  input  logic              chan_sel,
  input  logic [1:0]        comp_in,
  output logic [CODE_W-1:0] pull_code,
  output logic              freeze,
  output logic              done,
  output logic              fail,
  output logic [CODE_W-1:0] result
);
  localparam int TICK_W = (TICKS_PER_TEST > 1) ? $clog2(TICKS_PER_TEST) : 1;
  localparam logic [TICK_W-1:0] LAST_TICK = TICK_W'(TICKS_PER_TEST - 1);
  localparam logic [CODE_W-1:0] LAST_CODE = CODE_W'(NUM_TESTS - 1);

  logic              busy_q, sel_q, done_q, fail_q;
  logic [CODE_W-1:0] code_q, result_q;
  logic [TICK_W-1:0] tick_q;

  wire sense     = sel_q ? comp_in[1] : comp_in[0];
  wire judge     = busy_q && sample_tick && (tick_q == LAST_TICK);
  wire last_code = (code_q == LAST_CODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      sel_q    <= 1'b0;
      done_q   <= 1'b0;
      fail_q   <= 1'b0;
      code_q   <= '0;
      result_q <= '0;
      tick_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q <= 1'b1;
          sel_q  <= chan_sel;
          fail_q <= 1'b0;
          code_q <= '0;
          tick_q <= '0;
        end
      end else if (sample_tick) begin
        if (!judge) begin
          tick_q <= tick_q + 1'b1;
        end else begin
          tick_q <= '0;
          if (sense) begin
            result_q <= code_q;
            done_q   <= 1'b1;
            busy_q   <= 1'b0;
          end else if (last_code) begin
            fail_q <= 1'b1;
            done_q <= 1'b1;
            busy_q <= 1'b0;
          end else begin
            code_q <= code_q + 1'b1;
          end
        end
      end
    end
  end

  assign pull_code = busy_q ? code_q : result_q;
  assign freeze    = busy_q;
  assign done      = done_q;
  assign fail      = fail_q;
  assign result    = result_q;

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !freeze);

  // R6
  fail_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> done);

  // R5
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> (done && !fail));

  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && start && !sample_tick) |=> $stable(pull_code));

  // R3
  code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |-> (pull_code <= LAST_CODE));
endmodule

// File: tb/pullup_cal_seq_tb.sv
module pullup_cal_seq_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, sample_tick = 1'b0, start = 1'b0, chan_sel = 1'b0;
  logic [1:0] comp_in;
  logic [4:0] pull_code, result;
  logic freeze, done, fail;
  int thr0 = 31, thr1 = 31;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  assign comp_in[0] = (int'(pull_code) >= thr0);
  assign comp_in[1] = (int'(pull_code) >= thr1);

  pullup_cal_seq dut_i (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .start(start),
    .chan_sel(chan_sel), .comp_in(comp_in), .pull_code(pull_code),
    .freeze(freeze), .done(done), .fail(fail), .result(result));

  initial forever begin
    repeat (3) @(negedge clk);
    sample_tick = 1'b1;
    @(negedge clk);
    sample_tick = 1'b0;
  end

  localparam int NV = 7;
  localparam int VSEL [NV] = '{0, 1, 0, 1, 0, 1, 0};
  localparam int VT0  [NV] = '{4, 31, 0, 9, 27, 2, 13};
  localparam int VT1  [NV] = '{31, 6, 20, 0, 3, 17, 1};

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  int exp_res = 0;

  task automatic run_cal(input int sel, input int t0, input int t1, input bit poke_busy);
    int ticks = 0, cyc = 0, thr;
    bit frz_ok = 1;
    thr0 = t0; thr1 = t1;
    thr = (sel != 0) ? t1 : t0;
    @(negedge clk);
    chan_sel = sel[0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0; chan_sel = ~chan_sel;
    check(freeze == 1'b1, "R2 freeze after start", freeze, 1);
    check(fail == 1'b0, "R7 fail cleared by start", fail, 0);
    while (!done && cyc < 1000) begin
      if (!freeze) frz_ok = 0;
      if (sample_tick && freeze) ticks++;
      cyc++;
      if (poke_busy && cyc == 20) begin
        start = 1'b1; chan_sel = ~chan_sel;
      end else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    check(cyc < 1000, "R7 done seen", cyc, 0);
    check(frz_ok, "R2 freeze held during run", frz_ok, 1);
    check(freeze == 1'b0, "R2 freeze low at done", freeze, 0);
    if (thr < 28) begin
      exp_res = thr;
      check(fail == 1'b0, "R5 pass no fail", fail, 0);
      check(int'(result) == thr, "R4 R5 result code", result, thr);
      check(ticks == 3 * (thr + 1), "R3 R5 tick count", ticks, 3 * (thr + 1));
    end else begin
      check(fail == 1'b1, "R6 fail set", fail, 1);
      check(int'(result) == exp_res, "R6 result kept", result, exp_res);
      check(ticks == 84, "R6 tick count", ticks, 84);
    end
    @(negedge clk);
    check(done == 1'b0, "R7 done one clock", done, 0);
    check(pull_code == result, "R9 idle code equals result", pull_code, result);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!freeze && !done && !fail, "R1 reset flags", {freeze, done, fail}, 0);
    check(result == 5'd0 && pull_code == 5'd0, "R1 reset code", result, 0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) run_cal(VSEL[i], VT0[i], VT1[i], 1'b0);
    run_cal(0, 12, 31, 1'b0);
    run_cal(1, 5, 31, 1'b0);
    run_cal(0, 30, 2, 1'b0);
    check(fail == 1'b1, "R7 fail held while idle", fail, 1);
    run_cal(0, 15, 31, 1'b1);
    run_cal(1, 31, 11, 1'b1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule